// File: doc/BRIEF.md
# Nonvolatile memory program/erase timebase

This block derives the timing base for erase and program operations of an on-chip nonvolatile memory from the bus clock. A one-byte control register, written and read from the bus side, holds a prescale select and a divisor. The bus clock is optionally divided by eight, then divided by the divisor plus one. The result leaves the block as a one-cycle enable strobe, so every consumer stays in the bus clock domain. One strobe period is one program/erase timing pulse. Software normally picks settings that put the strobe rate between 150 kHz and 200 kHz, which gives pulses of 5 µs to 6.7 µs. For example, a 20 MHz bus with the prescaler on and a divisor of 12 gives about 192.3 kHz.

A sticky "divisor loaded" flag starts clear at reset and is set by the first register write, whatever value is written. Until that flag is set, no strobes are produced and the operation timer refuses to start. The operation timer takes a start request with a 16-bit pulse count. It stays busy for exactly that many strobes, then pulses done for one cycle.

The start request is a plain control pin and not a valid/ready stream. A request is taken or refused in the cycle it is presented, and a refused request is reported through the error pulse instead of being held off. A register write made while an operation runs is not back-pressured either: it is parked and applied when the operation finishes.

Top module: `nvm_clkdiv`

## Requirements
- R1: After reset the register reads 0x00, and busy, done, error and the strobe are all low.
- R2: The register's bit 7 is the loaded flag. The first write sets it, whatever the data (even 0x00), and it stays set until reset. Bit 7 of the write data is ignored. Bit 6 reads back the prescale select and bits 5:0 read back the divisor.
- R3: While the loaded flag is clear, the strobe never asserts.
- R4: With prescale 0 and divisor D, the strobe is one cycle wide and repeats every D+1 cycles. The first strobe is visible D+1 cycles after the clock edge that applied the write.
- R5: With prescale 1 and divisor D, the strobe repeats every 8*(D+1) cycles. The first strobe is visible 8*(D+1) cycles after the applying edge.
- R6: Every applied write restarts the prescaler and divider from zero, including a write of the value already held.
- R7: An accepted start raises busy on the next cycle. Strobes are counted from the cycle after the start edge onward. When the Nth strobe is counted, done is high and busy is low in the following cycle.
- R8: A start is refused when the loaded flag is clear, when the timer is busy, or when the pulse count is 0. A refused start gives a one-cycle error pulse on the next cycle and does not disturb a running operation.
- R9: A write made while busy does not change the readback or the strobe timing until the operation ends. It is applied at the edge that ends the done cycle, and the last such write wins.
- R10: Done is high for exactly one cycle per operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_data | input | 8 | Register write data (bit 6 prescale, bits 5:0 divisor) |
| cfg_rd_data | output | 8 | Live register contents (bit 7 loaded flag) |
| op_start | input | 1 | Start request for a timed operation |
| op_pulses | input | 16 | Number of timing pulses for the operation |
| op_busy | output | 1 | Operation in progress |
| op_done | output | 1 | One-cycle completion pulse |
| op_error | output | 1 | One-cycle pulse for a refused start |
| nvm_tick | output | 1 | One-cycle timing strobe |

## Verification
The divider is first run with directed settings at the extremes: divisor 0 and 63, with the prescaler off and on. These show whether the +1 in the division and the factor of eight are applied, and whether the count starts from zero after a write. Random divisor, prescale and pulse-count combinations follow, each timed from the applying edge to the first strobe, the strobe period and the done edge. These separate an off-by-one in the divider from one in the pulse counter. Starts are also tried before the first write, while busy and with a zero count, and writes are made during a run, to show that refusal and deferred configuration leave the running count alone.

// File: rtl/nvm_clkdiv_pkg.sv
package nvm_clkdiv_pkg;
  // timer state
  typedef enum logic {
    TMR_IDLE = 1'b0,
    TMR_RUN  = 1'b1
  } tmr_state_e;

  // fixed prescale ratio is 2**PRE_LOG2; helper for the all-ones count
  function automatic int unsigned pre_last(input int unsigned log2);
    return (1 << log2) - 1;
  endfunction
endpackage

// File: rtl/nvm_cfg_reg.sv
module nvm_cfg_reg #(
  parameter int DIV_W = 6,
  localparam int REG_W = DIV_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             busy,
  input  logic             done,
  output logic [REG_W-1:0] rd_data,
  output logic             loaded,
  output logic             prescale,
  output logic [DIV_W-1:0] divisor,
  output logic             restart
);
  logic             loaded_q, pre_q, pend_v, pend_pre;
  logic [DIV_W-1:0] div_q, pend_div;
  logic             direct_wr, deferred_wr, flush;

  always_comb begin
    direct_wr   = wr_en && !busy;
    deferred_wr = wr_en && busy;
    flush       = done && pend_v && !direct_wr;
    restart     = direct_wr || flush;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded_q <= 1'b0;
      pre_q    <= 1'b0;
      div_q    <= '0;
      pend_v   <= 1'b0;
      pend_pre <= 1'b0;
      pend_div <= '0;
    end else begin
      if (direct_wr) begin
        loaded_q <= 1'b1;
        pre_q    <= wr_data[DIV_W];
        div_q    <= wr_data[DIV_W-1:0];
        pend_v   <= 1'b0;
      end else if (flush) begin
        pre_q  <= pend_pre;
        div_q  <= pend_div;
        pend_v <= 1'b0;
      end
      if (deferred_wr) begin
        pend_v   <= 1'b1;
        pend_pre <= wr_data[DIV_W];
        pend_div <= wr_data[DIV_W-1:0];
      end
    end
  end

  assign loaded   = loaded_q;
  assign prescale = pre_q;
  assign divisor  = div_q;
  assign rd_data  = {loaded_q, pre_q, div_q};

  a_r2_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    loaded_q |=> loaded_q);
  a_r9_pending_only_in_op: assert property (@(posedge clk) disable iff (!rst_n)
    pend_v |-> (busy || done));
  a_r9_cfg_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(div_q) && $stable(pre_q)));
endmodule

// File: rtl/nvm_tick_gen.sv
module nvm_tick_gen #(
  parameter int DIV_W    = 6,
  parameter int PRE_LOG2 = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             restart,
  input  logic             prescale,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic             pre_tick;
  logic [DIV_W-1:0] div_cnt;
  logic             tick_q;

  generate
    if (PRE_LOG2 > 0) begin : g_pre
      logic [PRE_LOG2-1:0] pre_cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pre_cnt <= '0;
        else if (restart) pre_cnt <= '0;
        else if (prescale) pre_cnt <= pre_cnt + 1'b1;
      end
      assign pre_tick = prescale
        ? (pre_cnt == PRE_LOG2'(nvm_clkdiv_pkg::pre_last(PRE_LOG2))) : 1'b1;
    end else begin : g_nopre
      assign pre_tick = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      tick_q  <= 1'b0;
    end else if (restart) begin
      div_cnt <= '0;
      tick_q  <= 1'b0;
    end else begin
      tick_q <= enable && pre_tick && (div_cnt == divisor);
      if (pre_tick) div_cnt <= (div_cnt == divisor) ? '0 : div_cnt + 1'b1;
    end
  end

  assign tick = tick_q;

  a_r4_div_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    div_cnt <= divisor);
  a_r4_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (prescale || divisor != '0)) |=> !tick);
endmodule

// File: rtl/nvm_op_timer.sv
module nvm_op_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] count,
  input  logic             loaded,
  input  logic             tick,
  output logic             busy,
  output logic             done,
  output logic             err
);
  import nvm_clkdiv_pkg::*;

  tmr_state_e       st_q;
  logic [CNT_W-1:0] rem_q;
  logic             done_q, err_q, accept, refuse;

  always_comb begin
    accept = start && loaded && (st_q == TMR_IDLE) && (count != '0);
    refuse = start && !accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TMR_IDLE;
      rem_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= refuse;
      if (accept) begin
        st_q  <= TMR_RUN;
        rem_q <= count;
      end else if (st_q == TMR_RUN && tick) begin
        if (rem_q == CNT_W'(1)) begin
          st_q   <= TMR_IDLE;
          rem_q  <= '0;
          done_q <= 1'b1;
        end else begin
          rem_q <= rem_q - 1'b1;
        end
      end
    end
  end

  assign busy = (st_q == TMR_RUN);
  assign done = done_q;
  assign err  = err_q;

  a_r10_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  a_r8_err_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(start));
  a_r8_busy_needs_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> loaded);
  a_r7_rem_live: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rem_q != '0));
endmodule

// File: rtl/nvm_clkdiv.sv
module nvm_clkdiv #(
  parameter int DIV_W    = 6,
  parameter int PRE_LOG2 = 3,
  parameter int CNT_W    = 16,
  localparam int REG_W   = DIV_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic [REG_W-1:0] cfg_wr_data,
  output logic [REG_W-1:0] cfg_rd_data,
  input  logic             op_start,
  input  logic [CNT_W-1:0] op_pulses,
  output logic             op_busy,
  output logic             op_done,
  output logic             op_error,
  output logic             nvm_tick
);
  logic             loaded, prescale, restart, tick, busy, done;
  logic [DIV_W-1:0] divisor;

  nvm_cfg_reg #(.DIV_W(DIV_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data),
    .busy(busy), .done(done), .rd_data(cfg_rd_data), .loaded(loaded),
    .prescale(prescale), .divisor(divisor), .restart(restart)
  );

  nvm_tick_gen #(.DIV_W(DIV_W), .PRE_LOG2(PRE_LOG2)) u_tick (
    .clk(clk), .rst_n(rst_n), .enable(loaded), .restart(restart),
    .prescale(prescale), .divisor(divisor), .tick(tick)
  );

  nvm_op_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(op_start), .count(op_pulses),
    .loaded(loaded), .tick(tick), .busy(busy), .done(done), .err(op_error)
  );

  assign op_busy  = busy;
  assign op_done  = done;
  assign nvm_tick = tick;

  a_r3_no_tick_unloaded: assert property (@(posedge clk) disable iff (!rst_n)
    !loaded |-> !nvm_tick);
endmodule

// File: tb/nvm_clkdiv_tb_top.sv
`timescale 1ns/1ps
module nvm_clkdiv_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [7:0]  cfg_wr_data = '0;
  logic [7:0]  cfg_rd_data;
  logic        op_start = 1'b0;
  logic [15:0] op_pulses = '0;
  logic        op_busy, op_done, op_error, nvm_tick;

  int n_chk = 0;
  int n_bad = 0;
  bit summary_done = 0;

  always #5 clk = ~clk;

  nvm_clkdiv dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .op_start(op_start), .op_pulses(op_pulses),
    .op_busy(op_busy), .op_done(op_done), .op_error(op_error), .nvm_tick(nvm_tick)
  );

  function automatic int exp_period(input bit ps, input int d);
    return ps ? 8 * (d + 1) : d + 1;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [7:0] wd);
    return {1'b1, wd[6:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!summary_done) begin
      summary_done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // write; returns at the negedge right after the applying edge
  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  // cycles (negedges) until tick seen, limit bounded
  task automatic wait_tick(output int k);
    k = 0;
    for (int i = 1; i <= 2000; i++) begin
      @(negedge clk);
      if (nvm_tick) begin k = i; break; end
    end
  endtask

  task automatic check_div(input bit ps, input int d, input string req);
    int k1, k2;
    wr({1'b0, ps, 6'(d)});
    chk(cfg_rd_data == exp_rd({1'b0, ps, 6'(d)}), "R2", cfg_rd_data, exp_rd({1'b0, ps, 6'(d)}));
    wait_tick(k1);
    chk(k1 == exp_period(ps, d), req, k1, exp_period(ps, d));
    wait_tick(k2);
    chk(k2 == exp_period(ps, d), req, k2, exp_period(ps, d));
  endtask

  // start an op; verify busy, done timing; returns at negedge showing done
  task automatic run_op(input int n, input string req);
    int seen;
    bit ok;
    @(negedge clk);
    op_start = 1'b1; op_pulses = 16'(n);
    @(negedge clk);
    op_start = 1'b0;
    chk(op_busy == 1'b1, "R7", op_busy, 1);
    seen = (nvm_tick) ? 1 : 0;
    ok = 1;
    for (int i = 0; i < 40000 && seen < n; i++) begin
      @(negedge clk);
      if (op_done) ok = 0;
      if (nvm_tick) seen++;
    end
    chk(ok, "R7", ok, 1);
    @(negedge clk);
    chk(op_done == 1'b1 && op_busy == 1'b0, req, {op_done, op_busy}, 2);
  endtask

  initial begin
    #1500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    int k;
    bit any;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cfg_rd_data == 8'h00, "R1", cfg_rd_data, 0);
    chk({op_busy, op_done, op_error, nvm_tick} == 4'b0, "R1", {op_busy, op_done, op_error, nvm_tick}, 0);
    // R3 no tick before load
    any = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); any |= nvm_tick; end
    chk(!any, "R3", any, 0);
    // R8 start refused while unloaded
    @(negedge clk); op_start = 1'b1; op_pulses = 16'd3;
    @(negedge clk); op_start = 1'b0;
    chk(op_error && !op_busy, "R8", {op_error, op_busy}, 2);
    @(negedge clk);
    chk(!op_error, "R8", op_error, 0);
    // R2 write of 0x80 (bit7 ignored, flag set by any write)
    wr(8'h80);
    chk(cfg_rd_data == 8'h80, "R2", cfg_rd_data, 8'h80);
    wr(8'hBF);
    chk(cfg_rd_data == 8'hBF, "R2", cfg_rd_data, 8'hBF);
    // R4/R5 corners
    check_div(0, 0, "R4");
    check_div(0, 63, "R4");
    check_div(1, 0, "R5");
    check_div(1, 12, "R5");
    // R6 same-value rewrite restarts the phase
    wr(8'h05);
    repeat (3) @(negedge clk);
    wr(8'h05);
    wait_tick(k);
    chk(k == 6, "R6", k, 6);
    // R8 zero count refused
    @(negedge clk); op_start = 1'b1; op_pulses = 16'd0;
    @(negedge clk); op_start = 1'b0;
    chk(op_error && !op_busy, "R8", {op_error, op_busy}, 2);
    // R7/R10 directed op
    wr(8'h03);
    run_op(4, "R7");
    @(negedge clk);
    chk(!op_done, "R10", op_done, 0);
    // R8 start while busy + R9 deferred write
    @(negedge clk); op_start = 1'b1; op_pulses = 16'd3;
    @(negedge clk); op_start = 1'b0;
    @(negedge clk); op_start = 1'b1; op_pulses = 16'd9;
    @(negedge clk); op_start = 1'b0;
    chk(op_error && op_busy, "R8", {op_error, op_busy}, 3);
    @(negedge clk); cfg_wr_en = 1'b1; cfg_wr_data = 8'h11;
    @(negedge clk); cfg_wr_data = 8'h47;
    @(negedge clk); cfg_wr_en = 1'b0;
    chk(cfg_rd_data == 8'h83, "R9", cfg_rd_data, 8'h83);
    k = 0;
    for (int i = 0; i < 500 && !op_done; i++) begin
      @(negedge clk);
      if (!op_done) chk(cfg_rd_data == 8'h83, "R9", cfg_rd_data, 8'h83);
    end
    chk(op_done == 1'b1, "R9", op_done, 1);
    @(negedge clk);
    chk(cfg_rd_data == 8'hC7, "R9", cfg_rd_data, 8'hC7);
    wait_tick(k);
    chk(k == exp_period(1, 7), "R9", k, exp_period(1, 7));
    // random mix
    for (int it = 0; it < 16; it++) begin
      bit ps;
      int d, n;
      ps = 1'($urandom_range(0, 1));
      d  = $urandom_range(0, 63);
      n  = $urandom_range(1, 5);
      check_div(ps, d, ps ? "R5" : "R4");
      run_op(n, "R7");
      @(negedge clk);
      chk(!op_done, "R10", op_done, 0);
    end
    finish_run();
  end
endmodule